// File: doc/BRIEF.md
# Break Input and Main Output Enable Controller

This block owns the main output enable that gates every timer output stage. It watches two fault sources: an external break pin and an internal clock-failure fault. When break handling is switched on and either source becomes active, the main enable drops in the same instant. It does not wait for a clock edge. The break pin first passes through a two-stage synchronizer, a polarity select and an event-count filter. That filter rejects pulses shorter than a programmable number of samples.

After the fault is gone, the enable does not come back on its own. Software can set it again. When automatic re-enable is selected, it returns instead at the first update event with no break source active. An optional bidirectional mode turns the break pin into an open-drain signal. In that mode the block drives the pin low on any break, which tells devices on the same net about a fault found inside the chip. A disarm handshake lets software release the pin. Hardware clears the disarm flag once every break source has gone quiet.

Top module: `brk_moe_ctrl`

## Requirements
- R1: While reset is asserted and right after it, moe_o, pin_oe_o and disarm_o are all 0.
- R2: A break source counts only while brk_en_i is 1. With brk_en_i at 0, neither the fault input nor the pin affects moe_o.
- R3: While brk_en_i and fault_i are both 1, moe_o is 0 combinationally, with no clock edge needed.
- R4: brk_pol_i = 1 makes a high pin level the active break level. brk_pol_i = 0 makes a low pin level active.
- R5: The filter length N is 1 when filt_sel_i is 0, and min(filt_sel_i + 1, 8) otherwise. With N greater than 1, samples are taken only on cycles with sample_tick_i high. With sample_tick_i held high, a pin change made before clock edge k clears moe_o after edge k + N + 1.
- R6: A pin excursion lasting fewer than N consecutive samples is rejected and leaves moe_o at 1.
- R7: A moe_set_i pulse sets moe_o at the next edge when no break source is active. A pulse given while a break is active is ignored, and moe_o stays 0 after the break ends.
- R8: With auto_en_i = 1, moe_o returns at the first edge with update_i high and no active break. With auto_en_i = 0, update_i has no effect.
- R9: pin_oe_o, the open-drain pull-low enable, is 1 exactly when bidir_en_i is 1, a break source is active and disarm_o is 0.
- R10: A disarm_set_i pulse makes disarm_o 1 at the next edge. disarm_o returns to 0 at the first edge on which no break source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_pin_i | input | 1 | Raw break pin level |
| fault_i | input | 1 | Clock-failure fault, active high |
| brk_en_i | input | 1 | Enables both break sources |
| brk_pol_i | input | 1 | 1: pin active high, 0: pin active low |
| auto_en_i | input | 1 | Automatic re-enable on update events |
| filt_sel_i | input | 4 | Filter length select |
| bidir_en_i | input | 1 | Open-drain bidirectional pin mode |
| sample_tick_i | input | 1 | Filter sample strobe |
| update_i | input | 1 | Timer update event |
| moe_set_i | input | 1 | Software set of the main enable |
| disarm_set_i | input | 1 | Software disarm request |
| moe_o | output | 1 | Main output enable |
| pin_oe_o | output | 1 | Open-drain pull-low enable for the break pin |
| disarm_o | output | 1 | Disarm status |

## Verification
The bench builds the block with the default parameters: two synchronizer stages, a 4-bit filter select and a maximum filter length of 8. Those defaults let it try the single-sample path, a mid-range length of 4 and a select value that saturates at 8. Each case checks both the last cycle at which moe_o is still high and the cycle at which it drops. Holding the sample strobe low shows that a filter longer than one sample never accepts a change without strobes. A three-sample glitch against a length of 4 shows that short pulses are rejected.

// File: rtl/brk_pkg.sv
package brk_pkg;
  // Filter length: 1 for select 0, otherwise select+1 limited to max_len
  function automatic int unsigned filt_len(input int unsigned sel, input int unsigned max_len);
    int unsigned n;
    if (sel == 0) n = 1;
    else if (sel + 1 > max_len) n = max_len;
    else n = sel + 1;
    return n;
  endfunction
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/brk_filter.sv
module brk_filter #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned MAX_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             lvl_i,
  output logic             lvl_o
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             lvl_q;
  logic             take;

  always_comb begin
    len  = CNT_W'(brk_pkg::filt_len(int'(sel_i), MAX_LEN));
    // single-sample setting runs at clock rate
    take = (sel_i == '0) | tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (take) begin
      if (lvl_i != lvl_q) begin
        if ((cnt_q + CNT_W'(1)) >= len) begin
          lvl_q <= lvl_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/moe_core.sv
module moe_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_act_i,
  input  logic auto_en_i,
  input  logic update_i,
  input  logic moe_set_i,
  output logic moe_o
);
  logic moe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     moe_q <= 1'b0;
    else if (brk_act_i)              moe_q <= 1'b0;
    else if (moe_set_i)              moe_q <= 1'b1;
    else if (auto_en_i && update_i)  moe_q <= 1'b1;
  end

  // combinational kill: no edge needed to drop the enable
  assign moe_o = moe_q & ~brk_act_i;
endmodule

// File: rtl/brk_bidir.sv
module brk_bidir (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bidir_en_i,
  input  logic brk_act_i,
  input  logic disarm_set_i,
  output logic pin_oe_o,
  output logic disarm_o
);
  logic disarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           disarm_q <= 1'b0;
    else if (disarm_set_i) disarm_q <= 1'b1;
    else if (!brk_act_i)   disarm_q <= 1'b0;
  end

  assign pin_oe_o = bidir_en_i & brk_act_i & ~disarm_q;
  assign disarm_o = disarm_q;
endmodule

// File: rtl/brk_moe_ctrl.sv
module brk_moe_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_SEL_W  = 4,
  parameter int unsigned FILT_MAX    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  brk_pin_i,
  input  logic                  fault_i,
  input  logic                  brk_en_i,
  input  logic                  brk_pol_i,
  input  logic                  auto_en_i,
  input  logic [FILT_SEL_W-1:0] filt_sel_i,
  input  logic                  bidir_en_i,
  input  logic                  sample_tick_i,
  input  logic                  update_i,
  input  logic                  moe_set_i,
  input  logic                  disarm_set_i,
  output logic                  moe_o,
  output logic                  pin_oe_o,
  output logic                  disarm_o
);
  logic pin_sync;
  logic pin_act;
  logic pin_filt;
  logic brk_act;

  brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (brk_pin_i),
    .q_o   (pin_sync)
  );

  assign pin_act = brk_pol_i ? pin_sync : ~pin_sync;

  brk_filter #(.SEL_W(FILT_SEL_W), .MAX_LEN(FILT_MAX)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(sample_tick_i),
    .sel_i (filt_sel_i),
    .lvl_i (pin_act),
    .lvl_o (pin_filt)
  );

  assign brk_act = brk_en_i & (pin_filt | fault_i);

  moe_core u_moe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .brk_act_i(brk_act),
    .auto_en_i(auto_en_i),
    .update_i (update_i),
    .moe_set_i(moe_set_i),
    .moe_o    (moe_o)
  );

  brk_bidir u_bidir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bidir_en_i  (bidir_en_i),
    .brk_act_i   (brk_act),
    .disarm_set_i(disarm_set_i),
    .pin_oe_o    (pin_oe_o),
    .disarm_o    (disarm_o)
  );
endmodule

// File: rtl/brk_moe_ctrl_chk.sv
module brk_moe_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fault_i,
  input logic brk_en_i,
  input logic auto_en_i,
  input logic bidir_en_i,
  input logic update_i,
  input logic moe_set_i,
  input logic disarm_set_i,
  input logic moe_o,
  input logic pin_oe_o,
  input logic disarm_o
);
  assert_fault_kills_moe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_en_i && fault_i) |-> !moe_o);

  assert_moe_rise_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(moe_o) |-> ($past(moe_set_i) || ($past(auto_en_i) && $past(update_i))));

  assert_pin_drive_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> (bidir_en_i && !disarm_o));

  assert_pin_drive_on_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bidir_en_i && brk_en_i && fault_i && !disarm_o) |-> pin_oe_o);

  assert_disarm_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_set_i |=> disarm_o);
endmodule

bind brk_moe_ctrl brk_moe_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fault_i     (fault_i),
  .brk_en_i    (brk_en_i),
  .auto_en_i   (auto_en_i),
  .bidir_en_i  (bidir_en_i),
  .update_i    (update_i),
  .moe_set_i   (moe_set_i),
  .disarm_set_i(disarm_set_i),
  .moe_o       (moe_o),
  .pin_oe_o    (pin_oe_o),
  .disarm_o    (disarm_o)
);

// File: tb/brk_moe_ctrl_tb.sv
module brk_moe_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       brk_pin_i = 1'b0;
  logic       fault_i = 1'b0;
  logic       brk_en_i = 1'b1;
  logic       brk_pol_i = 1'b1;
  logic       auto_en_i = 1'b0;
  logic [3:0] filt_sel_i = 4'd0;
  logic       bidir_en_i = 1'b0;
  logic       sample_tick_i = 1'b1;
  logic       update_i = 1'b0;
  logic       moe_set_i = 1'b0;
  logic       disarm_set_i = 1'b0;
  logic       moe_o, pin_oe_o, disarm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  string      tag_q[$];
  logic [2:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  brk_moe_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .brk_pin_i(brk_pin_i), .fault_i(fault_i),
    .brk_en_i(brk_en_i), .brk_pol_i(brk_pol_i), .auto_en_i(auto_en_i),
    .filt_sel_i(filt_sel_i), .bidir_en_i(bidir_en_i), .sample_tick_i(sample_tick_i),
    .update_i(update_i), .moe_set_i(moe_set_i), .disarm_set_i(disarm_set_i),
    .moe_o(moe_o), .pin_oe_o(pin_oe_o), .disarm_o(disarm_o)
  );

  // monitor: pops expectations and compares against live outputs
  initial begin
    forever begin
      string      t;
      logic [2:0] e;
      wait (tag_q.size() != 0);
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if ({moe_o, pin_oe_o, disarm_o} !== e) begin
        errors++;
        $display("FAIL %s: {moe,pin_oe,disarm} actual=%b expected=%b", t,
                 {moe_o, pin_oe_o, disarm_o}, e);
      end
    end
  end

  task automatic expect3(input string t, input logic m, input logic o, input logic d);
    tag_q.push_back(t);
    exp_q.push_back({m, o, d});
    #1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rearm_auto();
    auto_en_i = 1'b1; update_i = 1'b1;
    edges(1);
    update_i = 1'b0; auto_en_i = 1'b0;
  endtask

  task automatic filt_case(input string t, input logic [3:0] sel, input int n, input logic pol);
    filt_sel_i = sel;
    brk_pin_i  = pol;
    edges(n + 1);
    expect3({t, " still on"}, 1'b1, 1'b0, 1'b0);
    edges(1);
    expect3({t, " cleared"}, 1'b0, 1'b0, 1'b0);
    brk_pin_i = ~pol;
    edges(n + 3);
    rearm_auto();
    expect3({t, " rearm"}, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    edges(2);
    expect3("R1 in reset", 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    edges(1);
    expect3("R1 after reset", 1'b0, 1'b0, 1'b0);

    // R7 software set
    moe_set_i = 1'b1; edges(1); moe_set_i = 1'b0;
    expect3("R7 set", 1'b1, 1'b0, 1'b0);

    // R3 async kill, R7 ignored set, R8 update gating
    fault_i = 1'b1;
    expect3("R3 async clear", 1'b0, 1'b0, 1'b0);
    moe_set_i = 1'b1; edges(1); moe_set_i = 1'b0;
    expect3("R7 set during break", 1'b0, 1'b0, 1'b0);
    fault_i = 1'b0;
    edges(1);
    expect3("R7 set ignored after break", 1'b0, 1'b0, 1'b0);
    update_i = 1'b1; edges(1); update_i = 1'b0;
    expect3("R8 update without auto", 1'b0, 1'b0, 1'b0);
    rearm_auto();
    expect3("R8 auto rearm", 1'b1, 1'b0, 1'b0);

    // R2 disabled sources
    brk_en_i = 1'b0; fault_i = 1'b1; brk_pin_i = 1'b1;
    edges(6);
    expect3("R2 sources ignored", 1'b1, 1'b0, 1'b0);
    brk_pin_i = 1'b0;
    edges(4);
    fault_i = 1'b0; brk_en_i = 1'b1;
    edges(1);

    // R5 / R4 filter lengths and polarity
    filt_case("R5 sel0 N1", 4'd0, 1, 1'b1);
    filt_case("R5 sel3 N4", 4'd3, 4, 1'b1);
    brk_pin_i = 1'b1;
    edges(4);
    brk_pol_i = 1'b0;
    edges(2);
    expect3("R4 high idle with low polarity", 1'b1, 1'b0, 1'b0);
    filt_case("R4 R5 sel12 N8 low active", 4'd12, 8, 1'b0);
    brk_pol_i = 1'b1; brk_pin_i = 1'b0;
    edges(12);
    rearm_auto();

    // R6 glitch rejection
    filt_sel_i = 4'd3;
    brk_pin_i = 1'b1; edges(3); brk_pin_i = 1'b0;
    edges(10);
    expect3("R6 short pulse rejected", 1'b1, 1'b0, 1'b0);

    // R5 sampling only on tick
    filt_sel_i = 4'd1; sample_tick_i = 1'b0; brk_pin_i = 1'b1;
    edges(10);
    expect3("R5 no tick no accept", 1'b1, 1'b0, 1'b0);
    sample_tick_i = 1'b1;
    edges(3);
    expect3("R5 tick accepts", 1'b0, 1'b0, 1'b0);
    brk_pin_i = 1'b0;
    edges(6);
    rearm_auto();
    expect3("R5 tick rearm", 1'b1, 1'b0, 1'b0);

    // R10 disarm without break clears next edge
    bidir_en_i = 1'b1;
    disarm_set_i = 1'b1; edges(1); disarm_set_i = 1'b0;
    expect3("R10 disarm set", 1'b1, 1'b0, 1'b1);
    edges(1);
    expect3("R10 disarm auto clear", 1'b1, 1'b0, 1'b0);

    // R9 bidir drive and disarm handshake
    fault_i = 1'b1;
    expect3("R9 drive low on break", 1'b0, 1'b1, 1'b0);
    disarm_set_i = 1'b1; edges(1); disarm_set_i = 1'b0;
    expect3("R9 R10 released by disarm", 1'b0, 1'b0, 1'b1);
    edges(2);
    expect3("R10 disarm held during break", 1'b0, 1'b0, 1'b1);
    fault_i = 1'b0;
    expect3("R10 disarm before edge", 1'b0, 1'b0, 1'b1);
    edges(1);
    expect3("R10 disarm cleared", 1'b0, 1'b0, 1'b0);
    bidir_en_i = 1'b0; fault_i = 1'b1;
    expect3("R9 no drive without bidir", 1'b0, 1'b0, 1'b0);
    fault_i = 1'b0;
    edges(1);
    moe_set_i = 1'b1; edges(1); moe_set_i = 1'b0;
    expect3("R7 set after break", 1'b1, 1'b0, 1'b0);

    wait (tag_q.size() == 0);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule